// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. Two counters run in cascade: a prescaler that divides by 2, 3, 5 or 7, and a scaler whose stage counts half of a mostly power-of-two ratio. Together they set the total division N = prescaler × scaler. Each stage is selected by a small code. The block emits a one-cycle tick each time the serial clock changes level, and a registered SCK level. While idle, SCK rests at the selected clock polarity.

The shift engine raises `run` for the length of a frame. On the first clock edge where `run` is seen high, the block captures the two codes and decodes them into counter limits. Those limits are held until `run` falls, so code changes in the middle of a frame have no effect. Dropping `run` clears both counters and returns SCK to its rest level on the next edge. Every scaler value is even, so N is always even and both half-periods last N/2 module clocks.

Top module: `spi_sck_divider`

## Requirements
- R1: While `rst` is high, `sck` follows `cpol` and `tick` is 0.
- R2: While `run` is low, `sck` takes the value of `cpol` on every edge and `tick` stays 0.
- R3: Prescaler code (`pre_code`, 2 bits) selects the ratio: 0 gives 2, 1 gives 3, 2 gives 5, 3 gives 7.
- R4: Scaler code (`scl_code`, 4 bits) selects the ratio: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, and code c from 4 to 15 gives 2^(c) (16 up to 32768).
- R5: With N = prescaler × scaler, the first SCK change happens N/2 edges after the capture edge (the first edge with `run` high), and each later change follows N/2 edges after the previous one, so both half-periods are equal.
- R6: `tick` is high for exactly the one cycle that follows each SCK change made while running. SCK never changes during a frame without `tick`.
- R7: Codes changed while `run` stays high do not alter the timing of the current frame. They apply from the next frame.
- R8: Dropping `run` in the middle of a frame returns `sck` to `cpol` on the next edge. The next frame starts with a full N/2 half-period.
- R9: The largest ratio, prescaler code 3 with scaler code 15, gives a half-period of 114688 module clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while the shift engine transfers a frame |
| cpol | input | 1 | Rest level of SCK, sampled while idle |
| pre_code | input | 2 | Prescaler selection code |
| scl_code | input | 4 | Scaler selection code |
| tick | output | 1 | One-cycle pulse after each SCK level change |
| sck | output | 1 | Registered serial clock level |

## Verification
The bench builds the block with its default code widths of 2 and 4 bits. This makes every entry of both ratio tables selectable. Every prescaler code is swept against a small scaler, and scaler codes up to 14 are swept against the smallest prescaler, so each table entry is checked on its own. The largest combination is run for one half-period of 114688 cycles, which exercises the full width of both counters.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

  // prescaler ratio selected by its code
  function automatic int pre_ratio(input int code);
    case (code)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  // half of the scaler ratio: 1,2,3,4 then powers of two from 8
  function automatic int scl_half(input int code);
    if (code < 4) return code + 1;
    return 1 << (code - 1);
  endfunction

endpackage

// File: rtl/sck_div_ctrl.sv
module sck_div_ctrl
  import sck_div_pkg::*;
#(
  parameter int PRE_CODE_W = 2,
  parameter int SCL_CODE_W = 4,
  parameter int PRE_CNT_W  = 3,
  parameter int SCL_CNT_W  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [PRE_CODE_W-1:0] pre_code,
  input  logic [SCL_CODE_W-1:0] scl_code,
  output logic                  active,
  output logic [PRE_CNT_W-1:0]  pre_last,
  output logic [SCL_CNT_W-1:0]  scl_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      pre_last <= '0;
      scl_last <= '0;
    end else if (!run) begin
      active <= 1'b0;
    end else if (!active) begin
      active   <= 1'b1;
      pre_last <= PRE_CNT_W'(pre_ratio(int'(pre_code)) - 1);
      scl_last <= SCL_CNT_W'(scl_half(int'(scl_code)) - 1);
    end
  end

endmodule

// File: rtl/sck_div_stage.sv
module sck_div_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         wrap
);

  logic [W-1:0] cnt;

  assign wrap = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sck_div_out.sv
module sck_div_out (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic active,
  input  logic cpol,
  input  logic half_done,
  output logic sck,
  output logic tick
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck  <= cpol;
      tick <= 1'b0;
    end else begin
      tick <= run && active && half_done;
      if (!run) begin
        sck <= cpol;
      end else if (active && half_done) begin
        sck <= ~sck;
      end
    end
  end

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int PRE_CODE_W = 2,
  parameter int SCL_CODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  cpol,
  input  logic [PRE_CODE_W-1:0] pre_code,
  input  logic [SCL_CODE_W-1:0] scl_code,
  output logic                  tick,
  output logic                  sck
);

  localparam int PRE_MAX      = 7;
  localparam int SCL_HALF_MAX = 1 << ((1 << SCL_CODE_W) - 2);
  localparam int PRE_CNT_W    = $clog2(PRE_MAX);
  localparam int SCL_CNT_W    = $clog2(SCL_HALF_MAX);

  logic                 active;
  logic [PRE_CNT_W-1:0] pre_last;
  logic [SCL_CNT_W-1:0] scl_last;
  logic                 run_en;
  logic                 pre_wrap;
  logic                 half_done;

  sck_div_ctrl #(
    .PRE_CODE_W(PRE_CODE_W),
    .SCL_CODE_W(SCL_CODE_W),
    .PRE_CNT_W (PRE_CNT_W),
    .SCL_CNT_W (SCL_CNT_W)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .pre_code(pre_code),
    .scl_code(scl_code),
    .active  (active),
    .pre_last(pre_last),
    .scl_last(scl_last)
  );

  assign run_en = active && run;

  sck_div_stage #(.W(PRE_CNT_W)) pre_i (
    .clk (clk),
    .rst (rst),
    .clr (!run_en),
    .en  (run_en),
    .last(pre_last),
    .wrap(pre_wrap)
  );

  sck_div_stage #(.W(SCL_CNT_W)) scl_i (
    .clk (clk),
    .rst (rst),
    .clr (!run_en),
    .en  (pre_wrap),
    .last(scl_last),
    .wrap(half_done)
  );

  sck_div_out out_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .active   (active),
    .cpol     (cpol),
    .half_done(half_done),
    .sck      (sck),
    .tick     (tick)
  );

endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic cpol,
  input logic tick,
  input logic sck
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !run |=> sck == $past(cpol)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick); // R2

  AST_TICK_MEANS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && tick |-> sck != $past(sck)); // R6

  AST_EDGE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(run) && sck != $past(sck) |-> tick); // R6

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && tick |-> $past(run)); // R5

endmodule

bind spi_sck_divider spi_sck_divider_chk chk_i (
  .clk (clk),
  .rst (rst),
  .run (run),
  .cpol(cpol),
  .tick(tick),
  .sck (sck)
);

// File: tb/spi_sck_divider_tb_top.sv
module spi_sck_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic [1:0] pre_code = '0;
  logic [3:0] scl_code = '0;
  logic       tick;
  logic       sck;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sck_divider dut_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cpol    (cpol),
    .pre_code(pre_code),
    .scl_code(scl_code),
    .tick    (tick),
    .sck     (sck)
  );

  function automatic int exp_pre(input int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int exp_scl(input int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: compare every tick with the scoreboard
  exp_t e;
  always @(negedge clk) begin
    if (!rst && tick) begin
      if (q.size() == 0) begin
        check(1'b0, "R6", "unexpected tick", 1, 0);
      end else begin
        e = q.pop_front();
        check(cyc == e.at, e.req, "tick cycle", cyc, e.at);
        check(sck == e.lvl, e.req, "sck level", int'(sck), int'(e.lvl));
      end
    end
  end

  // push k expected edges for a frame starting at this negedge
  task automatic push_frame(input int pc, input int sc, input logic pol,
                            input int k, input string req);
    int h = exp_pre(pc) * exp_scl(sc) / 2;
    int c0 = cyc;
    for (int i = 1; i <= k; i++) begin
      q.push_back('{c0 + 1 + i * h, pol ^ i[0], req});
    end
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic stop_and_check(input logic pol, input string req);
    run = 1'b0;
    @(negedge clk);
    check(sck == pol, req, "rest level after stop", int'(sck), int'(pol));
    check(tick == 1'b0, req, "tick after stop", int'(tick), 0);
  endtask

  task automatic run_frame(input int pc, input int sc, input logic pol,
                           input int k, input string req);
    cpol = pol;
    pre_code = pc[1:0];
    scl_code = sc[3:0];
    @(negedge clk);
    check(sck == pol, "R2", "idle level", int'(sck), int'(pol));
    run = 1'b1;
    push_frame(pc, sc, pol, k, req);
    wait_drain();
    stop_and_check(pol, "R2");
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    // R1: reset level follows polarity
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sck == 1'b1, "R1", "sck in reset", int'(sck), 1);
    check(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sck == 1'b0, "R1", "sck in reset", int'(sck), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: idle follows polarity without ticks
    cpol = 1'b1;
    @(negedge clk);
    check(sck == 1'b1, "R2", "idle follows cpol", int'(sck), 1);
    check(tick == 1'b0, "R2", "idle no tick", int'(tick), 0);
    cpol = 1'b0;
    @(negedge clk);
    check(sck == 1'b0, "R2", "idle follows cpol", int'(sck), 0);

    // R3: every prescaler code
    for (int p = 0; p < 4; p++) run_frame(p, 1, 1'b0, 4, "R3");

    // R4: scaler codes below the top one
    for (int s = 0; s < 15; s++) run_frame(0, s, 1'b0, (s < 10) ? 2 : 1, "R4");

    // R5: equal halves with polarity 1 and mixed codes
    run_frame(2, 2, 1'b1, 6, "R5");
    run_frame(1, 4, 1'b0, 4, "R5");

    // R7: change codes in the middle of a frame
    cpol = 1'b0;
    pre_code = 2'd1;
    scl_code = 4'd1;
    @(negedge clk);
    run = 1'b1;
    push_frame(1, 1, 1'b0, 3, "R7");
    repeat (2) @(negedge clk);
    pre_code = 2'd3;
    scl_code = 4'd3;
    wait_drain();
    stop_and_check(1'b0, "R7");
    @(negedge clk);
    run = 1'b1;
    push_frame(3, 3, 1'b0, 2, "R7");
    wait_drain();
    stop_and_check(1'b0, "R7");

    // R8: abort with sck away from rest level, then full restart
    pre_code = 2'd0;
    scl_code = 4'd2;
    @(negedge clk);
    run = 1'b1;
    push_frame(0, 2, 1'b0, 1, "R8");
    wait_drain();
    repeat (2) @(negedge clk);
    check(sck == 1'b1, "R8", "sck before abort", int'(sck), 1);
    stop_and_check(1'b0, "R8");
    run_frame(0, 2, 1'b0, 2, "R8");

    // R9: largest ratio, first half-period only
    run_frame(3, 15, 1'b0, 1, "R9");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6", "scoreboard empty", q.size(), 0);
    finish_up();
  end

endmodule